// File: doc/BRIEF.md
# Selectable G.711 Audio Compander

This block sits between a 16-bit two's-complement linear audio path and an 8-bit companded serial word. The transmit lane takes linear samples headed out of the converter side and either passes them through or compresses them to an 8-bit mu-law or A-law code. The receive lane takes incoming words and either passes them through or expands an 8-bit code back into a 16-bit linear sample. Each lane has its own 2-bit mode input, so the two directions may use different laws at the same time.

Each lane registers one sample per input strobe and presents it, with an output strobe, one clock later. A loopback input makes the receive lane consume the transmit lane's registered output in place of the external receive data. A byte-mode input marks the link as carrying 8-bit words: compressed codes always occupy bits 15:8 with bits 7:0 zero, and in byte mode linear words are also cut down to their upper byte.

Top module: `g711_compander`

## Requirements
- R1: In transmit mode 00 (linear) or 01 (reserved), with byte mode off, `tx_data_o` equals the `tx_data_i` value captured with `tx_valid_i`.
- R2: In transmit mode 10 (mu-law), the 14-bit value `tx_data_i[15:2]` is taken as signed; its magnitude is clipped at 8158, 33 is added, the segment s (0..7) is the highest set bit position minus 5, and the mantissa is bits s+4..s+1 of the biased magnitude. The code {sign(1 = negative), s[2:0], mantissa[3:0]} is inverted in all 8 bits and placed in `tx_data_o[15:8]`, with `tx_data_o[7:0]` zero.
- R3: In transmit mode 11 (A-law), the 13-bit value `tx_data_i[15:3]` is taken as signed; a negative value v is replaced by -v-1. The segment s is 0 below 32, else the highest set bit position minus 4; the mantissa is bits 4:1 for s = 0 and bits s+3..s otherwise. The code {sign(1 = non-negative), s, mantissa} is XORed with 0x55 and placed in `tx_data_o[15:8]`, low byte zero.
- R4: In receive mode 10, the code c = `rx_data_i[15:8]` is inverted; with segment s and mantissa m, the magnitude is 4*(((2m+33) << s) - 33), negated when the inverted sign bit is 1.
- R5: In receive mode 11, c is XORed with 0x55; the magnitude is 16m+8 for s = 0 and (16m+264) << (s-1) otherwise, positive when the de-masked bit 7 is 1 and negated when it is 0.
- R6: For every one of the 256 codes of each law, expanding and then compressing returns the same code, except that the mu-law negative-zero code 0x7F returns as 0xFF.
- R7: In receive mode 00 or 01, with byte mode off, `rx_data_o` equals the captured receive input word.
- R8: Each output strobe is high exactly one cycle after its input strobe; output data changes only on a cycle after a strobe; reset clears strobes and data to zero.
- R9: With `loopback` high the receive lane takes `tx_valid_o`/`tx_data_o` as its input, so a transmit sample reaches `rx_data_o` two cycles after `tx_valid_i`, and the external `rx_valid_i`/`rx_data_i` have no effect.
- R10: With `byte_mode` high, linear and reserved modes clear bits 7:0 of the output word in both lanes; companded outputs are unchanged.
- R11: The two lanes' modes are independent: different laws on the two lanes in the same cycle each give their own law's result.
- R12: A mode change without a strobe leaves the held output unchanged; the mode is read only together with a sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_mode | input | 2 | Transmit lane mode: 00 linear, 01 reserved, 10 mu-law, 11 A-law |
| rx_mode | input | 2 | Receive lane mode, same encoding |
| loopback | input | 1 | Feed transmit output into the receive lane |
| byte_mode | input | 1 | 8-bit word link: clear low byte of linear words |
| tx_valid_i | input | 1 | Transmit sample strobe |
| tx_data_i | input | 16 | Transmit linear sample |
| tx_valid_o | output | 1 | Transmit result strobe |
| tx_data_o | output | 16 | Transmit word (code in bits 15:8 when companded) |
| rx_valid_i | input | 1 | Receive word strobe |
| rx_data_i | input | 16 | Receive word (code in bits 15:8 when companded) |
| rx_valid_o | output | 1 | Receive result strobe |
| rx_data_o | output | 16 | Receive linear sample |

## Verification
The bench expands all 256 codes of both laws and recompresses them, so a wrong segment boundary, an off-by-one shift, or an inversion mask applied to the wrong bits shows up as a code that fails to return, and the mu-law negative zero is singled out because a design that kept a signed zero would return 0x7F. A linear sweep including -32768, -1, 0 and 32767 catches a missing clip or bias, which would wrap the largest negative input to a small code. Loopback is tested with a conflicting external strobe held high, which a design that merged the two sources would pass through one cycle early. Mode changes between strobes and byte mode on companded words target designs that decode mode combinationally at the output or mask the wrong byte.

// File: rtl/g711_pkg.sv
package g711_pkg;

  localparam int LIN_W   = 16;
  localparam int CODE_W  = 8;
  localparam int PAD_W   = LIN_W - CODE_W;
  localparam int SEG_N   = 8;
  localparam int MANT_W  = 4;
  localparam int MU_BIAS = 33;
  localparam int MU_CLIP = 8158;

  typedef enum logic [1:0] {
    CMP_LINEAR = 2'b00,
    CMP_RSVD   = 2'b01,
    CMP_ULAW   = 2'b10,
    CMP_ALAW   = 2'b11
  } cmp_mode_e;

  localparam logic [CODE_W-1:0] MU_FLIP = 8'hFF;
  localparam logic [CODE_W-1:0] A_FLIP  = 8'h55;

  // mu-law compression of a 16-bit linear sample (uses the top 14 bits)
  function automatic logic [CODE_W-1:0] mu_compress(input logic [LIN_W-1:0] lin);
    logic [13:0] s;
    logic        neg;
    logic [14:0] mag;
    logic [2:0]  seg;
    logic [14:0] sh;
    s   = lin[LIN_W-1:2];
    neg = s[13];
    mag = neg ? (15'd0 - {s[13], s}) : {1'b0, s};
    if (mag > 15'(MU_CLIP)) mag = 15'(MU_CLIP);
    mag = mag + 15'(MU_BIAS);
    seg = 3'd0;
    for (int i = 1; i < SEG_N; i++) begin
      if (mag[5+i]) seg = 3'(i);
    end
    sh = mag >> (4'(seg) + 4'd1);
    return {neg, seg, sh[MANT_W-1:0]} ^ MU_FLIP;
  endfunction

  // mu-law expansion to a 16-bit linear sample
  function automatic logic [LIN_W-1:0] mu_expand(input logic [CODE_W-1:0] code);
    logic [CODE_W-1:0] u;
    logic [LIN_W-1:0]  t;
    u = code ^ MU_FLIP;
    t = ({9'd0, u[3:0], 3'b000} + 16'd132) << u[6:4];
    return u[7] ? (16'd132 - t) : (t - 16'd132);
  endfunction

  // A-law compression of a 16-bit linear sample (uses the top 13 bits)
  function automatic logic [CODE_W-1:0] a_compress(input logic [LIN_W-1:0] lin);
    logic [12:0] p;
    logic        neg;
    logic [11:0] mag;
    logic [2:0]  seg;
    logic [11:0] sh;
    logic [3:0]  mant;
    p   = lin[LIN_W-1:3];
    neg = p[12];
    mag = neg ? ~p[11:0] : p[11:0];
    seg = 3'd0;
    for (int i = 1; i < SEG_N; i++) begin
      if (mag[4+i]) seg = 3'(i);
    end
    if (seg == 3'd0) begin
      mant = mag[4:1];
    end else begin
      sh   = mag >> seg;
      mant = sh[MANT_W-1:0];
    end
    return {~neg, seg, mant} ^ A_FLIP;
  endfunction

  // A-law expansion to a 16-bit linear sample
  function automatic logic [LIN_W-1:0] a_expand(input logic [CODE_W-1:0] code);
    logic [CODE_W-1:0] a;
    logic [LIN_W-1:0]  t;
    a = code ^ A_FLIP;
    t = {8'd0, a[3:0], 4'b0000};
    if (a[6:4] == 3'd0) begin
      t = t + 16'd8;
    end else begin
      t = (t + 16'h0108) << (a[6:4] - 3'd1);
    end
    return a[7] ? t : (16'd0 - t);
  endfunction

  // linear pass-through, optionally cut to the upper byte
  function automatic logic [LIN_W-1:0] lin_pass(input logic [LIN_W-1:0] d,
                                                 input logic byte_only);
    return byte_only ? {d[LIN_W-1:PAD_W], {PAD_W{1'b0}}} : d;
  endfunction

endpackage

// File: rtl/g711_tx_lane.sv
module g711_tx_lane
  import g711_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             byte_mode,
  input  logic             valid_i,
  input  logic [LIN_W-1:0] data_i,
  output logic             valid_o,
  output logic [LIN_W-1:0] data_o
);

  logic [LIN_W-1:0] word_nxt;

  always_comb begin
    case (cmp_mode_e'(mode))
      CMP_ULAW: word_nxt = {mu_compress(data_i), {PAD_W{1'b0}}};
      CMP_ALAW: word_nxt = {a_compress(data_i), {PAD_W{1'b0}}};
      default:  word_nxt = lin_pass(data_i, byte_mode);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= word_nxt;
    end
  end

endmodule

// File: rtl/g711_rx_lane.sv
module g711_rx_lane
  import g711_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             byte_mode,
  input  logic             valid_i,
  input  logic [LIN_W-1:0] data_i,
  output logic             valid_o,
  output logic [LIN_W-1:0] data_o
);

  logic [CODE_W-1:0] code_in;
  logic [LIN_W-1:0]  sample_nxt;

  assign code_in = data_i[LIN_W-1:PAD_W];

  always_comb begin
    case (cmp_mode_e'(mode))
      CMP_ULAW: sample_nxt = mu_expand(code_in);
      CMP_ALAW: sample_nxt = a_expand(code_in);
      default:  sample_nxt = lin_pass(data_i, byte_mode);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= sample_nxt;
    end
  end

endmodule

// File: rtl/g711_compander.sv
module g711_compander
  import g711_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       tx_mode,
  input  logic [1:0]       rx_mode,
  input  logic             loopback,
  input  logic             byte_mode,
  input  logic             tx_valid_i,
  input  logic [LIN_W-1:0] tx_data_i,
  output logic             tx_valid_o,
  output logic [LIN_W-1:0] tx_data_o,
  input  logic             rx_valid_i,
  input  logic [LIN_W-1:0] rx_data_i,
  output logic             rx_valid_o,
  output logic [LIN_W-1:0] rx_data_o
);

  // receive-lane input after the loopback choice, visible to the checker
  logic             rx_sel_valid;
  logic [LIN_W-1:0] rx_sel_data;

  assign rx_sel_valid = loopback ? tx_valid_o : rx_valid_i;
  assign rx_sel_data  = loopback ? tx_data_o  : rx_data_i;

  g711_tx_lane u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (tx_mode),
    .byte_mode (byte_mode),
    .valid_i   (tx_valid_i),
    .data_i    (tx_data_i),
    .valid_o   (tx_valid_o),
    .data_o    (tx_data_o)
  );

  g711_rx_lane u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (rx_mode),
    .byte_mode (byte_mode),
    .valid_i   (rx_sel_valid),
    .data_i    (rx_sel_data),
    .valid_o   (rx_valid_o),
    .data_o    (rx_data_o)
  );

endmodule

// File: rtl/g711_compander_chk.sv
module g711_compander_chk
  import g711_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       tx_mode,
  input logic [1:0]       rx_mode,
  input logic             loopback,
  input logic             byte_mode,
  input logic             tx_valid_i,
  input logic [LIN_W-1:0] tx_data_i,
  input logic             tx_valid_o,
  input logic [LIN_W-1:0] tx_data_o,
  input logic             rx_valid_o,
  input logic [LIN_W-1:0] rx_data_o,
  input logic             rx_sel_valid,
  input logic [LIN_W-1:0] rx_sel_data
);

  AST_TX_STROBE_UP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_i |=> tx_valid_o);  // R8
  AST_TX_STROBE_DN: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid_i |=> !tx_valid_o);  // R8
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid_i |=> $stable(tx_data_o));  // R12
  AST_RX_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_sel_valid |=> rx_valid_o);  // R8
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_sel_valid |=> $stable(rx_data_o));  // R12
  AST_LOOP_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (loopback && tx_valid_o) |=> rx_valid_o);  // R9
  AST_LOOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (loopback && !tx_valid_o) |=> !rx_valid_o);  // R9
  AST_TX_LINEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_i && !tx_mode[1] && !byte_mode) |=> tx_data_o == $past(tx_data_i));  // R1
  AST_RX_LINEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_sel_valid && !rx_mode[1] && !byte_mode) |=> rx_data_o == $past(rx_sel_data));  // R7
  AST_CODE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_i && tx_mode[1]) |=> tx_data_o[PAD_W-1:0] == '0);  // R2
  AST_BYTE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_i && byte_mode) |=> tx_data_o[PAD_W-1:0] == '0);  // R10
  AST_MU_ZERO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_i && tx_mode == 2'b10 && tx_data_i[LIN_W-1:2] == '0)
      |=> tx_data_o[LIN_W-1:PAD_W] == 8'hFF);  // R2

endmodule

bind g711_compander g711_compander_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tx_mode      (tx_mode),
  .rx_mode      (rx_mode),
  .loopback     (loopback),
  .byte_mode    (byte_mode),
  .tx_valid_i   (tx_valid_i),
  .tx_data_i    (tx_data_i),
  .tx_valid_o   (tx_valid_o),
  .tx_data_o    (tx_data_o),
  .rx_valid_o   (rx_valid_o),
  .rx_data_o    (rx_data_o),
  .rx_sel_valid (rx_sel_valid),
  .rx_sel_data  (rx_sel_data)
);

// File: tb/g711_compander_bench.sv
`timescale 1ns/1ps
module g711_compander_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  tx_mode = 2'b00;
  logic [1:0]  rx_mode = 2'b00;
  logic        loopback = 1'b0;
  logic        byte_mode = 1'b0;
  logic        tx_valid_i = 1'b0;
  logic [15:0] tx_data_i = 16'h0;
  logic        tx_valid_o;
  logic [15:0] tx_data_o;
  logic        rx_valid_i = 1'b0;
  logic [15:0] rx_data_i = 16'h0;
  logic        rx_valid_o;
  logic [15:0] rx_data_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  g711_compander u_g711_compander (
    .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .rx_mode(rx_mode),
    .loopback(loopback), .byte_mode(byte_mode),
    .tx_valid_i(tx_valid_i), .tx_data_i(tx_data_i),
    .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o),
    .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i),
    .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o)
  );

  // ---------------- reference arithmetic, restated from the requirements
  function automatic int ref_mu_enc(input int x);
    int s, mag, seg, code;
    s = x >>> 2;
    mag = (s < 0) ? -s : s;
    if (mag > 8158) mag = 8158;
    mag = mag + 33;
    seg = 0;
    while (seg < 7 && mag >= (64 << seg)) seg++;
    code = ((s < 0) ? 128 : 0) | (seg << 4) | ((mag >> (seg + 1)) & 15);
    return code ^ 255;
  endfunction

  function automatic int ref_a_enc(input int x);
    int p, mag, seg, sgn, sh;
    p = x >>> 3;
    sgn = (p >= 0) ? 128 : 0;
    mag = (p >= 0) ? p : (-p - 1);
    seg = 0;
    while (seg < 7 && mag >= (32 << seg)) seg++;
    sh = (seg == 0) ? 1 : seg;
    return (sgn | (seg << 4) | ((mag >> sh) & 15)) ^ 85;
  endfunction

  function automatic int ref_mu_dec(input int c);
    int u, m, seg, mag;
    u = c ^ 255;
    m = u & 15;
    seg = (u >> 4) & 7;
    mag = (((2 * m + 33) << seg) - 33) * 4;
    return (u & 128) ? -mag : mag;
  endfunction

  function automatic int ref_a_dec(input int c);
    int a, m, seg, mag;
    a = c ^ 85;
    m = a & 15;
    seg = (a >> 4) & 7;
    mag = (seg == 0) ? (16 * m + 8) : ((16 * m + 264) << (seg - 1));
    return (a & 128) ? mag : -mag;
  endfunction

  // ---------------- helpers
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_tx(input logic [15:0] d);
    @(negedge clk);
    tx_valid_i = 1'b1;
    tx_data_i  = d;
    @(negedge clk);
    tx_valid_i = 1'b0;
  endtask

  task automatic send_rx(input logic [15:0] d);
    @(negedge clk);
    rx_valid_i = 1'b1;
    rx_data_i  = d;
    @(negedge clk);
    rx_valid_i = 1'b0;
  endtask

  function automatic int sx(input logic [15:0] v);
    return int'($signed(v));
  endfunction

  // ---------------- scenarios
  task automatic t_reset;
    chk(tx_valid_o == 1'b0 && rx_valid_o == 1'b0, "R8 reset strobes", int'(tx_valid_o) + int'(rx_valid_o), 0);
    chk(tx_data_o == 16'h0, "R8 reset tx data", int'(tx_data_o), 0);
    chk(rx_data_o == 16'h0, "R8 reset rx data", int'(rx_data_o), 0);
  endtask

  task automatic t_linear;
    logic [15:0] pats [4] = '{16'h0000, 16'hFFFF, 16'h8001, 16'h5A3C};
    for (int md = 0; md < 2; md++) begin
      tx_mode = 2'(md);
      rx_mode = 2'(md);
      for (int i = 0; i < 4; i++) begin
        send_tx(pats[i]);
        chk(tx_data_o == pats[i], "R1 tx linear/reserved", int'(tx_data_o), int'(pats[i]));
        send_rx(pats[i] ^ 16'h0F0F);
        chk(rx_data_o == (pats[i] ^ 16'h0F0F), "R7 rx linear/reserved", int'(rx_data_o), int'(pats[i] ^ 16'h0F0F));
      end
    end
  endtask

  task automatic t_strobe;
    tx_mode = 2'b00;
    @(negedge clk);
    tx_valid_i = 1'b1;
    tx_data_i  = 16'h1111;
    @(negedge clk);
    tx_valid_i = 1'b0;
    chk(tx_valid_o == 1'b1, "R8 strobe one cycle later", int'(tx_valid_o), 1);
    tx_data_i = 16'h2222;
    @(negedge clk);
    chk(tx_valid_o == 1'b0, "R8 strobe drops", int'(tx_valid_o), 0);
    chk(tx_data_o == 16'h1111, "R8 data held without strobe", int'(tx_data_o), 16'h1111);
  endtask

  task automatic t_encode_sweep;
    int edges [6] = '{-32768, -1, 0, 1, 32767, -32767};
    for (int law = 0; law < 2; law++) begin
      tx_mode = law ? 2'b11 : 2'b10;
      for (int i = 0; i < 6; i++) begin
        send_tx(16'(edges[i]));
        if (law) chk(tx_data_o == {8'(ref_a_enc(edges[i])), 8'h00}, "R3 A-law encode edge", int'(tx_data_o), ref_a_enc(edges[i]) << 8);
        else     chk(tx_data_o == {8'(ref_mu_enc(edges[i])), 8'h00}, "R2 mu-law encode edge", int'(tx_data_o), ref_mu_enc(edges[i]) << 8);
      end
      for (int x = -32768; x < 32768; x += 97) begin
        send_tx(16'(x));
        if (law) chk(tx_data_o == {8'(ref_a_enc(x)), 8'h00}, "R3 A-law encode", int'(tx_data_o), ref_a_enc(x) << 8);
        else     chk(tx_data_o == {8'(ref_mu_enc(x)), 8'h00}, "R2 mu-law encode", int'(tx_data_o), ref_mu_enc(x) << 8);
      end
    end
  endtask

  task automatic t_code_roundtrip;
    int exp_code;
    for (int law = 0; law < 2; law++) begin
      tx_mode = law ? 2'b11 : 2'b10;
      rx_mode = law ? 2'b11 : 2'b10;
      for (int c = 0; c < 256; c++) begin
        send_rx({8'(c), 8'h00});
        if (law) chk(sx(rx_data_o) == ref_a_dec(c), "R5 A-law decode", sx(rx_data_o), ref_a_dec(c));
        else     chk(sx(rx_data_o) == ref_mu_dec(c), "R4 mu-law decode", sx(rx_data_o), ref_mu_dec(c));
        send_tx(rx_data_o);
        exp_code = (!law && c == 8'h7F) ? 8'hFF : c;
        chk(tx_data_o[15:8] == 8'(exp_code), "R6 expand then compress", int'(tx_data_o[15:8]), exp_code);
      end
    end
  endtask

  task automatic t_loopback;
    int x;
    x = -1234;
    loopback  = 1'b1;
    tx_mode   = 2'b10;
    rx_mode   = 2'b10;
    rx_valid_i = 1'b1;
    rx_data_i  = 16'h1234;
    @(negedge clk);
    @(negedge clk);
    chk(rx_valid_o == 1'b0, "R9 external strobe ignored", int'(rx_valid_o), 0);
    tx_valid_i = 1'b1;
    tx_data_i  = 16'(x);
    @(negedge clk);
    tx_valid_i = 1'b0;
    chk(rx_valid_o == 1'b0, "R9 no early receive strobe", int'(rx_valid_o), 0);
    @(negedge clk);
    chk(rx_valid_o == 1'b1, "R9 receive strobe after two cycles", int'(rx_valid_o), 1);
    chk(sx(rx_data_o) == ref_mu_dec(ref_mu_enc(x)), "R9 looped sample", sx(rx_data_o), ref_mu_dec(ref_mu_enc(x)));
    @(negedge clk);
    chk(rx_valid_o == 1'b0, "R9 single looped strobe", int'(rx_valid_o), 0);
    tx_mode = 2'b00;
    rx_mode = 2'b00;
    send_tx(16'h7E5A);
    @(negedge clk);
    chk(rx_data_o == 16'h7E5A, "R9 linear loop", int'(rx_data_o), 16'h7E5A);
    rx_valid_i = 1'b0;
    loopback   = 1'b0;
  endtask

  task automatic t_byte_mode;
    byte_mode = 1'b1;
    tx_mode = 2'b00;
    rx_mode = 2'b01;
    send_tx(16'hABCD);
    chk(tx_data_o == 16'hAB00, "R10 tx linear byte mode", int'(tx_data_o), 16'hAB00);
    send_rx(16'h3C96);
    chk(rx_data_o == 16'h3C00, "R10 rx reserved byte mode", int'(rx_data_o), 16'h3C00);
    tx_mode = 2'b11;
    send_tx(16'h1234);
    chk(tx_data_o == {8'(ref_a_enc(16'h1234)), 8'h00}, "R10 companded word unchanged", int'(tx_data_o), ref_a_enc(16'h1234) << 8);
    rx_mode = 2'b10;
    send_rx(16'h8F00);
    chk(sx(rx_data_o) == ref_mu_dec(8'h8F), "R10 expanded sample unchanged", sx(rx_data_o), ref_mu_dec(8'h8F));
    byte_mode = 1'b0;
  endtask

  task automatic t_independent;
    tx_mode = 2'b10;
    rx_mode = 2'b11;
    @(negedge clk);
    tx_valid_i = 1'b1;
    tx_data_i  = 16'h0C40;
    rx_valid_i = 1'b1;
    rx_data_i  = 16'h2A00;
    @(negedge clk);
    tx_valid_i = 1'b0;
    rx_valid_i = 1'b0;
    chk(tx_data_o[15:8] == 8'(ref_mu_enc(16'h0C40)), "R11 tx mu with rx A", int'(tx_data_o[15:8]), ref_mu_enc(16'h0C40));
    chk(sx(rx_data_o) == ref_a_dec(8'h2A), "R11 rx A with tx mu", sx(rx_data_o), ref_a_dec(8'h2A));
  endtask

  task automatic t_mode_between;
    logic [15:0] held_tx, held_rx;
    tx_mode = 2'b10;
    rx_mode = 2'b11;
    send_tx(16'hF000);
    send_rx(16'h5500);
    held_tx = tx_data_o;
    held_rx = rx_data_o;
    tx_mode = 2'b00;
    rx_mode = 2'b00;
    tx_data_i = 16'h4321;
    rx_data_i = 16'h8765;
    repeat (3) @(negedge clk);
    chk(tx_data_o == held_tx, "R12 tx held over mode change", int'(tx_data_o), int'(held_tx));
    chk(rx_data_o == held_rx, "R12 rx held over mode change", int'(rx_data_o), int'(held_rx));
    send_tx(16'h4321);
    chk(tx_data_o == 16'h4321, "R12 new mode on next sample", int'(tx_data_o), 16'h4321);
  endtask

  // ---------------- watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // ---------------- main
  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_linear();
    t_strobe();
    t_encode_sweep();
    t_code_roundtrip();
    t_loopback();
    t_byte_mode();
    t_independent();
    t_mode_between();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule